// File: doc/BRIEF.md
# Dual-Stream Nibble Link Arbiter

This block drives a 4-bit output link from two source queues. One queue holds trigger cluster records of one to four clusters. The other holds readout words of sixteen strips each. The block pops one record at a time from a first-word-fall-through read interface, turns it into a framed run of nibbles and shifts the frame out most significant nibble first. Frames leave back to back with no gap. The link carries 0000 whenever nothing is being sent, and no frame header can start with that value.

The stream to serve is chosen only where one frame ends and the next begins, so a frame is never cut short. The choice depends on an operating mode that is derived from the two queues' full flags:
- With neither queue full, trigger records win over readout words.
- With only the trigger queue full, readout is held back and a trigger-off status line is raised.
- With only the readout queue full, trigger records are held back and a busy status line is raised.
- With both queues full, both status lines are raised and trigger records still come first.

Top module: `nibble_link_arbiter`

## Requirements
- R1: After a synchronous active-high reset, and in every cycle without a frame in flight, the link is 0000. Both status lines are low after reset.
- R2: A cluster record holds the cluster-count code in bits [29:28], where code c means c+1 clusters. Cluster i (i = 0..3) sits in bits [27-7i:21-7i], an address of 5 bits above a size of 2 bits. Its frame is 01, the count code, then the address and size of each valid cluster in index order, all most significant bit first and zero padded to whole nibbles. This gives 3, 5, 7 or 8 nibbles. Slots past the count never appear on the link.
- R3: A readout record holds the word number in bits [18:16] and the strips in bits [15:0]. Its frame is 1, the 3-bit word number, then strip bits 15 down to 0. This gives 5 nibbles.
- R4: A pop is asserted in the cycle a stream is chosen, and the frame's first nibble appears on the link in the next cycle. A new frame may follow the last nibble of the previous one with no idle cycle.
- R5: No pop occurs while a frame still has nibbles left after the current one, so a started frame is never interrupted.
- R6: With neither queue full, a waiting trigger record is served before a waiting readout word.
- R7: With only the trigger queue full, readout words are never popped, trigger records are served, and trigger-off reads 1 while busy reads 0.
- R8: With only the readout queue full, trigger records are never popped, readout words are served, and busy reads 1 while trigger-off reads 0.
- R9: With both queues full, trigger records are served first and then readout words, and both status lines read 1.
- R10: The status lines take the mode sampled at a frame boundary (idle, or the cycle showing a frame's last nibble) and hold it until the next boundary.
- R11: A queue whose empty flag is set is never popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| trg_data | input | 30 | Head record of the trigger cluster queue |
| trg_empty | input | 1 | Trigger queue has no record |
| trg_full | input | 1 | Trigger queue is full |
| trg_pop | output | 1 | Take the head trigger record this cycle |
| ro_data | input | 19 | Head word of the readout queue |
| ro_empty | input | 1 | Readout queue has no word |
| ro_full | input | 1 | Readout queue is full |
| ro_pop | output | 1 | Take the head readout word this cycle |
| link_data | output | 4 | Output link nibble |
| trigger_off | output | 1 | Trigger stream is being throttled |
| busy | output | 1 | Readout stream is being throttled |

## Verification
Two things fall in one cycle: a frame's final nibble is on the link while the arbiter picks and pops the next record. In that same cycle the status lines latch the new mode. The bench provokes this by keeping both queues stocked and by flipping the full flags while a frame is in mid-flight. Each clock it compares the link, the pops and the status lines with a behavioural model, which builds frames as bit queues and decides the next stream from the flags at the boundary.

// File: rtl/nla_pkg.sv
package nla_pkg;

    // Operating mode, encoded as {readout_full, trigger_full}
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_DERATED  = 2'd1,
        MODE_BUSY     = 2'd2,
        MODE_SURVIVAL = 2'd3
    } link_mode_e;

    function automatic link_mode_e mode_of(input logic trg_full, input logic ro_full);
        return link_mode_e'({ro_full, trg_full});
    endfunction

endpackage

// File: rtl/nla_frame_builder.sv
module nla_frame_builder #(
    parameter int ADDR_W  = 5,
    parameter int SIZE_W  = 2,
    parameter int MAX_CL  = 4,
    parameter int WNUM_W  = 3,
    parameter int STRIP_W = 16,
    parameter int LINK_W  = 4,
    parameter int FRAME_W = 32,
    parameter int LEN_W   = 4,
    localparam int CL_W   = ADDR_W + SIZE_W,
    localparam int CNT_W  = $clog2(MAX_CL),
    localparam int TRG_W  = CNT_W + MAX_CL * CL_W,
    localparam int RO_W   = WNUM_W + STRIP_W
) (
    input  logic [TRG_W-1:0]   trg_data,
    input  logic [RO_W-1:0]    ro_data,
    output logic [FRAME_W-1:0] trg_frame,
    output logic [LEN_W-1:0]   trg_len,
    output logic [FRAME_W-1:0] ro_frame,
    output logic [LEN_W-1:0]   ro_len
);
    localparam logic [1:0] TRG_ID   = 2'b01;
    localparam int         TRG_FRM_W = 2 + TRG_W;
    localparam int         RO_FRM_W  = 1 + RO_W;
    localparam int         BODY_W    = MAX_CL * CL_W;

    logic [CNT_W-1:0]  cnt_code;
    logic [BODY_W-1:0] kept;

    assign cnt_code = trg_data[TRG_W-1 -: CNT_W];

    // Clusters beyond the count are forced to zero so padding stays clean
    for (genvar g = 0; g < MAX_CL; g++) begin : g_slot
        assign kept[(MAX_CL-g)*CL_W-1 -: CL_W] =
            (int'(cnt_code) >= g) ? trg_data[(MAX_CL-g)*CL_W-1 -: CL_W] : '0;
    end

    always_comb begin
        int nbits;
        nbits     = 2 + CNT_W + (int'(cnt_code) + 1) * CL_W;
        trg_frame = FRAME_W'({TRG_ID, cnt_code, kept}) << (FRAME_W - TRG_FRM_W);
        trg_len   = LEN_W'((nbits + LINK_W - 1) / LINK_W);
        ro_frame  = FRAME_W'({1'b1, ro_data}) << (FRAME_W - RO_FRM_W);
        ro_len    = LEN_W'((RO_FRM_W + LINK_W - 1) / LINK_W);
    end

endmodule

// File: rtl/nla_serializer.sv
module nla_serializer #(
    parameter int LINK_W  = 4,
    parameter int FRAME_W = 32,
    parameter int LEN_W   = 4,
    localparam int MAX_NIB = FRAME_W / LINK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   len,
    output logic [LINK_W-1:0]  link,
    output logic               at_boundary
);
    typedef struct packed {
        logic [FRAME_W-1:0] shift;
        logic [LEN_W-1:0]   rem;
        logic [LINK_W-1:0]  link;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (load) begin
            ser_d.link  = frame[FRAME_W-1 -: LINK_W];
            ser_d.shift = frame << LINK_W;
            ser_d.rem   = len - LEN_W'(1);
        end else if (ser_q.rem != '0) begin
            ser_d.link  = ser_q.shift[FRAME_W-1 -: LINK_W];
            ser_d.shift = ser_q.shift << LINK_W;
            ser_d.rem   = ser_q.rem - LEN_W'(1);
        end else begin
            ser_d.link  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign link        = ser_q.link;
    assign at_boundary = (ser_q.rem == '0);

    // R2: every frame handed over has a legal nibble count
    p_len_range_r2: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0 && int'(len) <= MAX_NIB));

    // R4: the nibble after a load is a header, never the idle code
    p_header_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (link != '0));

    // R5: a frame in flight counts down one nibble per cycle
    p_countdown_r5: assert property (@(posedge clk) disable iff (rst)
        (ser_q.rem != '0) |=> (ser_q.rem == $past(ser_q.rem) - LEN_W'(1)));

endmodule

// File: rtl/nla_mode_arbiter.sv
module nla_mode_arbiter
    import nla_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic at_boundary,
    input  logic trg_empty,
    input  logic ro_empty,
    input  logic trg_full,
    input  logic ro_full,
    output logic pop_trg,
    output logic pop_ro,
    output logic trigger_off,
    output logic busy
);
    typedef struct packed {
        link_mode_e mode;
    } arb_t;

    arb_t       arb_d, arb_q;
    link_mode_e mode_now;
    logic       allow_trg, allow_ro;

    always_comb begin
        mode_now  = mode_of(trg_full, ro_full);
        allow_trg = (mode_now != MODE_BUSY);
        allow_ro  = (mode_now != MODE_DERATED);
        pop_trg   = !rst && at_boundary && allow_trg && !trg_empty;
        pop_ro    = !rst && at_boundary && allow_ro && !ro_empty && !pop_trg;
        arb_d     = arb_q;
        if (at_boundary) begin
            arb_d.mode = mode_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arb_q <= '{mode: MODE_NORMAL};
        end else begin
            arb_q <= arb_d;
        end
    end

    assign trigger_off = (arb_q.mode == MODE_DERATED) || (arb_q.mode == MODE_SURVIVAL);
    assign busy        = (arb_q.mode == MODE_BUSY)    || (arb_q.mode == MODE_SURVIVAL);

    // R6: a waiting trigger record blocks readout unless trigger is throttled
    p_priority_r6: assert property (@(posedge clk) disable iff (rst)
        (!trg_empty && !(ro_full && !trg_full)) |-> !pop_ro);

    // R7: derated mode never takes readout
    p_derated_r7: assert property (@(posedge clk) disable iff (rst)
        (trg_full && !ro_full) |-> !pop_ro);

    // R8: busy mode never takes trigger data
    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (ro_full && !trg_full) |-> !pop_trg);

    // R9: survival mode still favours trigger data
    p_survival_r9: assert property (@(posedge clk) disable iff (rst)
        (trg_full && ro_full && !trg_empty) |-> !pop_ro);

    // R10: status lines move only after a boundary cycle
    p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(at_boundary) |-> ($stable(trigger_off) && $stable(busy)));

endmodule

// File: rtl/nibble_link_arbiter.sv
module nibble_link_arbiter #(
    parameter int ADDR_W  = 5,
    parameter int SIZE_W  = 2,
    parameter int MAX_CL  = 4,
    parameter int WNUM_W  = 3,
    parameter int STRIP_W = 16,
    parameter int LINK_W  = 4,
    localparam int CL_W   = ADDR_W + SIZE_W,
    localparam int CNT_W  = $clog2(MAX_CL),
    localparam int TRG_W  = CNT_W + MAX_CL * CL_W,
    localparam int RO_W   = WNUM_W + STRIP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TRG_W-1:0]  trg_data,
    input  logic              trg_empty,
    input  logic              trg_full,
    output logic              trg_pop,
    input  logic [RO_W-1:0]   ro_data,
    input  logic              ro_empty,
    input  logic              ro_full,
    output logic              ro_pop,
    output logic [LINK_W-1:0] link_data,
    output logic              trigger_off,
    output logic              busy
);
    localparam int TRG_FRM_W = 2 + TRG_W;
    localparam int RO_FRM_W  = 1 + RO_W;
    localparam int RAW_W     = (TRG_FRM_W > RO_FRM_W) ? TRG_FRM_W : RO_FRM_W;
    localparam int FRAME_W   = ((RAW_W + LINK_W - 1) / LINK_W) * LINK_W;
    localparam int MAX_NIB   = FRAME_W / LINK_W;
    localparam int LEN_W     = $clog2(MAX_NIB + 1);

    logic [FRAME_W-1:0] trg_frame, ro_frame, sel_frame;
    logic [LEN_W-1:0]   trg_len, ro_len, sel_len;
    logic               at_boundary, load;

    nla_frame_builder #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_CL(MAX_CL),
        .WNUM_W(WNUM_W), .STRIP_W(STRIP_W), .LINK_W(LINK_W),
        .FRAME_W(FRAME_W), .LEN_W(LEN_W)
    ) u_builder (
        .trg_data (trg_data),
        .ro_data  (ro_data),
        .trg_frame(trg_frame),
        .trg_len  (trg_len),
        .ro_frame (ro_frame),
        .ro_len   (ro_len)
    );

    nla_mode_arbiter u_arbiter (
        .clk        (clk),
        .rst        (rst),
        .at_boundary(at_boundary),
        .trg_empty  (trg_empty),
        .ro_empty   (ro_empty),
        .trg_full   (trg_full),
        .ro_full    (ro_full),
        .pop_trg    (trg_pop),
        .pop_ro     (ro_pop),
        .trigger_off(trigger_off),
        .busy       (busy)
    );

    always_comb begin
        load      = trg_pop || ro_pop;
        sel_frame = trg_pop ? trg_frame : ro_frame;
        sel_len   = trg_pop ? trg_len   : ro_len;
    end

    nla_serializer #(
        .LINK_W(LINK_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
    ) u_serializer (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .frame      (sel_frame),
        .len        (sel_len),
        .link       (link_data),
        .at_boundary(at_boundary)
    );

    // R5: the arbiter only pops where the serializer is at a frame boundary
    p_pop_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        (trg_pop || ro_pop) |-> at_boundary);

    // R1: a boundary without a pop leaves the link idle
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(at_boundary) && !$past(trg_pop || ro_pop)) |-> (link_data == '0));

    // R11: an empty queue is never popped
    p_no_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
        !((trg_pop && trg_empty) || (ro_pop && ro_empty)));

endmodule

// File: tb/nibble_link_arbiter_test.sv
`timescale 1ns/1ps
module nibble_link_arbiter_test;

    typedef logic [3:0] nib_q_t[$];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] trg_data = '0;
    logic        trg_empty = 1'b1, trg_full = 1'b0, trg_pop;
    logic [18:0] ro_data = '0;
    logic        ro_empty = 1'b1, ro_full = 1'b0, ro_pop;
    logic [3:0]  link_data;
    logic        trigger_off, busy;

    int checks = 0;
    int errors = 0;

    logic        bf_tf = 1'b0, bf_rf = 1'b0;
    logic [29:0] tq[$];
    logic [18:0] rq[$];
    logic [3:0]  m_nib[$];
    logic [3:0]  m_link = '0, n_link = '0;
    logic        m_toff = 1'b0, n_toff = 1'b0, m_busy = 1'b0, n_busy = 1'b0;
    string       m_tag = "R1", n_tag = "R1", cur_tag = "R1";

    always #5 clk = ~clk;

    nibble_link_arbiter uut (
        .clk(clk), .rst(rst),
        .trg_data(trg_data), .trg_empty(trg_empty), .trg_full(trg_full), .trg_pop(trg_pop),
        .ro_data(ro_data), .ro_empty(ro_empty), .ro_full(ro_full), .ro_pop(ro_pop),
        .link_data(link_data), .trigger_off(trigger_off), .busy(busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic nib_q_t to_nibbles(input bit b[$]);
        nib_q_t r;
        while (b.size() % 4 != 0) b.push_back(1'b0);
        for (int k = 0; k < b.size(); k += 4)
            r.push_back({b[k], b[k+1], b[k+2], b[k+3]});
        return r;
    endfunction

    function automatic nib_q_t trg_nibbles(input logic [29:0] rec);
        bit b[$];
        int n;
        n = int'(rec[29:28]) + 1;
        b.push_back(1'b0); b.push_back(1'b1);
        b.push_back(rec[29]); b.push_back(rec[28]);
        for (int i = 0; i < n; i++) begin
            logic [4:0] a;
            logic [1:0] s;
            a = rec[27-7*i -: 5];
            s = rec[22-7*i -: 2];
            for (int j = 4; j >= 0; j--) b.push_back(a[j]);
            for (int j = 1; j >= 0; j--) b.push_back(s[j]);
        end
        return to_nibbles(b);
    endfunction

    function automatic nib_q_t ro_nibbles(input logic [18:0] rec);
        bit b[$];
        b.push_back(1'b1);
        for (int j = 18; j >= 0; j--) b.push_back(rec[j]);
        return to_nibbles(b);
    endfunction

    // Unused slots carry all-ones junk that must never reach the link
    function automatic logic [29:0] make_trg(input int n_cl, input int base);
        logic [29:0] r;
        r = '1;
        r[29:28] = 2'(n_cl - 1);
        for (int i = 0; i < n_cl; i++) begin
            r[27-7*i -: 5] = 5'((base + 7*i) % 32);
            r[22-7*i -: 2] = 2'((base + i) % 4);
        end
        return r;
    endfunction

    function automatic logic [18:0] make_ro(input int wnum, input int pat);
        return {3'(wnum), 16'(pat)};
    endfunction

    task automatic cyc_eval();
        bit    bnd, allow_t, allow_r, ept, epr;
        string stag, ptag;
        nib_q_t fr;
        trg_empty = (tq.size() == 0);
        trg_data  = trg_empty ? '0 : tq[0];
        ro_empty  = (rq.size() == 0);
        ro_data   = ro_empty ? '0 : rq[0];
        trg_full  = bf_tf;
        ro_full   = bf_rf;
        #2;
        chk(m_tag, "link nibble", int'(link_data), int'(m_link));
        if (m_toff && m_busy) stag = "R9";
        else if (m_toff)      stag = "R7";
        else if (m_busy)      stag = "R8";
        else                  stag = "R10";
        chk(stag, "trigger_off", int'(trigger_off), int'(m_toff));
        chk(stag, "busy", int'(busy), int'(m_busy));

        bnd     = (m_nib.size() == 0);
        allow_t = !(bf_rf && !bf_tf);
        allow_r = !(bf_tf && !bf_rf);
        ept     = bnd && allow_t && (tq.size() > 0);
        epr     = bnd && allow_r && (rq.size() > 0) && !ept;
        if (!bnd)                               ptag = "R5";
        else if (tq.size() == 0 && rq.size() == 0) ptag = "R11";
        else if (bf_tf && bf_rf)                ptag = "R9";
        else if (bf_tf)                         ptag = "R7";
        else if (bf_rf)                         ptag = "R8";
        else                                    ptag = "R6";
        chk(ptag, "trigger pop", int'(trg_pop), int'(ept));
        chk(ptag, "readout pop", int'(ro_pop), int'(epr));

        n_toff = bnd ? bf_tf : m_toff;
        n_busy = bnd ? bf_rf : m_busy;
        if (ept) begin
            fr = trg_nibbles(tq.pop_front());
            n_link = fr.pop_front(); n_tag = "R4"; m_nib = fr; cur_tag = "R2";
        end else if (epr) begin
            fr = ro_nibbles(rq.pop_front());
            n_link = fr.pop_front(); n_tag = "R4"; m_nib = fr; cur_tag = "R3";
        end else if (!bnd) begin
            n_link = m_nib.pop_front(); n_tag = cur_tag;
        end else begin
            n_link = '0; n_tag = "R1";
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            cyc_eval();
            @(posedge clk);
            m_link = n_link; m_toff = n_toff; m_busy = n_busy; m_tag = n_tag;
            #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk("R1", "reset link", int'(link_data), 0);
        chk("R1", "reset trigger_off", int'(trigger_off), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset pops", int'(trg_pop) + int'(ro_pop), 0);
        @(posedge clk); #1;

        // Normal mode: all cluster counts queued ahead of a readout word
        rq.push_back(make_ro(0, 16'hA5C3));
        for (int c = 1; c <= 4; c++) tq.push_back(make_trg(c, 3 * c));
        run(40);

        // Readout stream with a trigger record arriving mid-frame
        for (int w = 1; w <= 3; w++) rq.push_back(make_ro(w, 16'h1234 * w));
        run(2);
        tq.push_back(make_trg(2, 11));
        run(30);

        // Derated: readout waits, trigger is still served
        bf_tf = 1'b1;
        rq.push_back(make_ro(4, 16'hFFFF));
        run(10);
        tq.push_back(make_trg(1, 30));
        run(10);
        bf_tf = 1'b0;
        run(10);

        // Busy: trigger waits, readout is served
        bf_rf = 1'b1;
        tq.push_back(make_trg(3, 5));
        tq.push_back(make_trg(4, 9));
        run(8);
        rq.push_back(make_ro(5, 16'h0001));
        run(10);
        bf_rf = 1'b0;
        run(25);

        // Survival: both queued, trigger first
        bf_tf = 1'b1; bf_rf = 1'b1;
        rq.push_back(make_ro(6, 16'h8000));
        tq.push_back(make_trg(3, 17));
        run(20);

        // Full flags change in mid-frame: status waits for the boundary
        bf_tf = 1'b0; bf_rf = 1'b0;
        run(3);
        rq.push_back(make_ro(7, 16'h5A5A));
        rq.push_back(make_ro(0, 16'h0F0F));
        run(2);
        bf_tf = 1'b1;
        run(2);
        bf_rf = 1'b1;
        run(12);
        bf_tf = 1'b0; bf_rf = 1'b0;
        run(12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule